// File: doc/BRIEF.md
# Scrambled Super-Pixel Frame Packer

This block collects 30-bit super-pixel packets from an upstream stream and packs them, four at a time, into 128-bit frames for a serialiser. Each frame starts with an 8-bit header. The header holds a fixed marker nibble and one even-parity bit for each packet slot. The 120 payload bits are scrambled additively with the running output of a 58-stage linear feedback shift register. This breaks up long runs of equal bits on the line.

A frame is always on offer once reset is released. The serialiser takes a frame by raising `frm_ready`. That cycle is the frame deadline: the packets that are pending go into the frame, the oldest first, and any empty slot is filled with an all-ones idle packet. While `sync_req` is high, the frame output is replaced by a programmable 128-bit pattern, and pending packets are held for a later frame.

Top module: `frame_packer`

## Requirements
- R1: When `sync_req` is low, `frm_data[127:124]` is 4'h5.
- R2: When `sync_req` is low, `frm_data[120+i]` equals the XOR of the 30 scrambled bits of slot i, for i = 0..3.
- R3: Slot i occupies `frm_data[119-30*i -: 30]`. Slot 0 holds the oldest pending packet, and later slots hold younger ones in arrival order.
- R4: Payload bits 119:0 equal the raw slot contents XOR a 120-bit word W. W comes from a 58-bit state s, seeded to 58'h2AB_CDEF_0123_4567 at reset. For k = 0..119: f = s[57]^s[38]; W[119-k] = f; s = {s[56:0], f}. The stepped state replaces s after each frame handshake, sync frames included.
- R5: A slot with no pending packet at the deadline carries the idle value 30'h3FFFFFFF before scrambling.
- R6: While `sync_req` is high, `frm_data` equals `sync_pattern`. Packets pending at a sync handshake are kept, not dropped.
- R7: `pkt_ready` is low when four packets are pending and no frame is being taken without sync. A packet offered while `pkt_ready` is low is not taken.
- R8: A packet accepted in the same cycle as a non-sync frame handshake is not in that frame. It becomes slot 0 of the next frame.
- R9: The first frame after reset has four idle slots scrambled with the seed word.
- R10: `frm_valid` is low while `rst_n` is low and high from the first clock edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pkt_valid | input | 1 | Upstream packet offered |
| pkt_data | input | 30 | Super-pixel packet |
| pkt_ready | output | 1 | Packet taken this cycle if valid |
| sync_req | input | 1 | Replace frames by the sync pattern |
| sync_pattern | input | 128 | Pattern sent while syncing |
| frm_valid | output | 1 | Frame on offer |
| frm_ready | input | 1 | Serialiser takes the frame this cycle |
| frm_data | output | 128 | Output frame |

## Verification
`frm_data` and `pkt_ready` depend combinationally on registered state and on the current `sync_req`, `sync_pattern` and `frm_ready`. A change in inputs is visible in the same cycle. The effect of a clock edge (packet stored, slots cleared, scrambler stepped) appears in the cycle right after that edge. `frm_valid` rises one edge after reset is released. The bench drives inputs just after the falling edge, waits one time unit, and compares every output against a cycle model kept in step with each rising edge.

// File: rtl/fp_pkg.sv
// Shared constants for the frame packer.
// Assumes a 4-bit marker nibble at the top of every frame.
package fp_pkg;
    localparam logic [3:0] FP_MARK = 4'h5;
    localparam int FP_PKT_W  = 30;
    localparam int FP_SLOTS  = 4;
    localparam int FP_LFSR_W = 58;
    localparam int FP_TAP    = 39;
endpackage

// File: rtl/fp_collect.sv
// Packet collector: holds up to SLOTS packets in arrival order.
// Assumes the caller never pushes into a full store without a flush in the same cycle.
module fp_collect #(
    parameter int PKT_W = 30,
    parameter int SLOTS = 4,
    localparam int CNT_W = $clog2(SLOTS + 1),
    localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        push,
    input  logic [PKT_W-1:0]            data,
    input  logic                        flush,
    output logic [SLOTS-1:0][PKT_W-1:0] slots,
    output logic [CNT_W-1:0]            cnt
);
    // Store packets; a flush empties the store, and a push in the same cycle goes to slot 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            slots <= '0;
        end else if (flush) begin
            cnt <= push ? CNT_W'(1) : '0;
            if (push) slots[0] <= data;
        end else if (push) begin
            slots[cnt[IDX_W-1:0]] <= data;
            cnt <= cnt + CNT_W'(1);
        end
    end

    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(cnt == CNT_W'(SLOTS) && push && !flush));

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && !push) |=> $stable(cnt));

    p_flush_push_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && push) |=> (cnt == CNT_W'(1)));
endmodule

// File: rtl/fp_scramble.sv
// Scrambler source: a Fibonacci LFSR stepped WORD_W times per frame.
// Assumes SEED is non-zero; the state only moves on a frame handshake.
module fp_scramble #(
    parameter int            LFSR_W = 58,
    parameter int            TAP    = 39,
    parameter int            WORD_W = 120,
    parameter logic [57:0]   SEED   = 58'h2AB_CDEF_0123_4567
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              advance,
    output logic [WORD_W-1:0] word
);
    logic [LFSR_W-1:0] state;
    logic [LFSR_W-1:0] state_nx;

    // Unroll WORD_W steps: each feedback bit is one word bit, MSB first.
    always_comb begin
        logic [LFSR_W-1:0] s;
        logic              fb;
        s    = state;
        word = '0;
        for (int k = 0; k < WORD_W; k++) begin
            fb = s[LFSR_W-1] ^ s[TAP-1];
            word[WORD_W-1-k] = fb;
            s = {s[LFSR_W-2:0], fb};
        end
        state_nx = s;
    end

    // Hold the state; step it once per delivered frame.
    always_ff @(posedge clk) begin
        if (!rst_n)       state <= SEED[LFSR_W-1:0];
        else if (advance) state <= state_nx;
    end

    p_lfsr_live_r4: assert property (@(posedge clk) disable iff (!rst_n)
        state != '0);

    p_lfsr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !advance |=> $stable(state));
endmodule

// File: rtl/fp_assemble.sv
// Frame builder: fills slots (idle where empty), scrambles, adds parity header,
// and substitutes the sync pattern when asked. Purely combinational.
module fp_assemble #(
    parameter int PKT_W = 30,
    parameter int SLOTS = 4,
    localparam int CNT_W = $clog2(SLOTS + 1),
    localparam int PAY_W = PKT_W * SLOTS,
    localparam int FRM_W = 4 + SLOTS + PAY_W
) (
    input  logic [SLOTS-1:0][PKT_W-1:0] slots,
    input  logic [CNT_W-1:0]            cnt,
    input  logic [PAY_W-1:0]            word,
    input  logic                        sync_req,
    input  logic [FRM_W-1:0]            sync_pattern,
    output logic [FRM_W-1:0]            frame
);
    logic [PAY_W-1:0] payload;
    logic [SLOTS-1:0] parity;

    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        logic [PKT_W-1:0] raw;
        logic [PKT_W-1:0] scr;
        // Pick the stored packet or the idle filler, then scramble and take parity.
        always_comb begin
            raw = (CNT_W'(i) < cnt) ? slots[i] : {PKT_W{1'b1}};
            scr = raw ^ word[PAY_W-1-i*PKT_W -: PKT_W];
        end
        assign payload[PAY_W-1-i*PKT_W -: PKT_W] = scr;
        assign parity[i] = ^scr;
    end

    // Choose between the sync pattern and the packed frame.
    always_comb begin
        if (sync_req) frame = sync_pattern;
        else          frame = {fp_pkg::FP_MARK, parity, payload};
    end
endmodule

// File: rtl/frame_packer.sv
// Top: scrambled frame packer. Offers a frame every cycle after reset; a
// handshake on frm_ready is the frame deadline. Assumes SLOTS+4 header bits.
module frame_packer #(
    parameter int          PKT_W  = fp_pkg::FP_PKT_W,
    parameter int          SLOTS  = fp_pkg::FP_SLOTS,
    parameter int          LFSR_W = fp_pkg::FP_LFSR_W,
    parameter int          TAP    = fp_pkg::FP_TAP,
    parameter logic [57:0] SEED   = 58'h2AB_CDEF_0123_4567,
    localparam int CNT_W = $clog2(SLOTS + 1),
    localparam int PAY_W = PKT_W * SLOTS,
    localparam int FRM_W = 4 + SLOTS + PAY_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pkt_valid,
    input  logic [PKT_W-1:0] pkt_data,
    output logic             pkt_ready,
    input  logic             sync_req,
    input  logic [FRM_W-1:0] sync_pattern,
    output logic             frm_valid,
    input  logic             frm_ready,
    output logic [FRM_W-1:0] frm_data
);
    logic                        hs;
    logic                        flush;
    logic                        push;
    logic [SLOTS-1:0][PKT_W-1:0] slots;
    logic [CNT_W-1:0]            cnt;
    logic [PAY_W-1:0]            word;

    // Frame offer goes high one edge after reset release.
    always_ff @(posedge clk) begin
        if (!rst_n) frm_valid <= 1'b0;
        else        frm_valid <= 1'b1;
    end

    // Handshake decode and upstream flow control.
    always_comb begin
        hs        = frm_valid & frm_ready;
        flush     = hs & ~sync_req;
        pkt_ready = (cnt < CNT_W'(SLOTS)) | flush;
        push      = pkt_valid & pkt_ready;
    end

    fp_collect #(.PKT_W(PKT_W), .SLOTS(SLOTS)) u_collect (
        .clk(clk), .rst_n(rst_n), .push(push), .data(pkt_data),
        .flush(flush), .slots(slots), .cnt(cnt)
    );

    fp_scramble #(.LFSR_W(LFSR_W), .TAP(TAP), .WORD_W(PAY_W), .SEED(SEED)) u_scr (
        .clk(clk), .rst_n(rst_n), .advance(hs), .word(word)
    );

    fp_assemble #(.PKT_W(PKT_W), .SLOTS(SLOTS)) u_asm (
        .slots(slots), .cnt(cnt), .word(word), .sync_req(sync_req),
        .sync_pattern(sync_pattern), .frame(frm_data)
    );

    p_valid_up_r10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> frm_valid);

    p_cnt_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(SLOTS));
endmodule

// File: tb/sim_frame_packer.sv
module sim_frame_packer;
    logic         clk = 1'b0;
    logic         rst_n;
    logic         pkt_valid;
    logic [29:0]  pkt_data;
    logic         pkt_ready;
    logic         sync_req;
    logic [127:0] sync_pattern;
    logic         frm_valid;
    logic         frm_ready;
    logic [127:0] frm_data;

    int total = 0;
    int bad = 0;
    logic [57:0]  mstate;
    logic [29:0]  mslot [4];
    int           mcnt;
    logic         mvalid;
    logic [31:0]  lcg = 32'h1234_5678;

    always #2 clk = ~clk;   // 250 MHz

    frame_packer u0 (
        .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_data(pkt_data),
        .pkt_ready(pkt_ready), .sync_req(sync_req), .sync_pattern(sync_pattern),
        .frm_valid(frm_valid), .frm_ready(frm_ready), .frm_data(frm_data)
    );

    function automatic logic [31:0] rnd();
        lcg = lcg * 32'd1103515245 + 32'd12345;
        return lcg;
    endfunction

    // Scrambler word per R4.
    function automatic logic [119:0] scr_word(input logic [57:0] st);
        logic [57:0] s = st;
        logic [119:0] w = '0;
        for (int k = 0; k < 120; k++) begin
            logic f;
            f = s[57] ^ s[38];
            w[119-k] = f;
            s = {s[56:0], f};
        end
        return w;
    endfunction

    function automatic logic [57:0] scr_next(input logic [57:0] st);
        logic [57:0] s = st;
        for (int k = 0; k < 120; k++) s = {s[56:0], s[57] ^ s[38]};
        return s;
    endfunction

    function automatic logic [127:0] exp_frame();
        logic [119:0] w = scr_word(mstate);
        logic [119:0] pay;
        logic [3:0]   par;
        for (int i = 0; i < 4; i++) begin
            logic [29:0] raw;
            raw = (i < mcnt) ? mslot[i] : 30'h3FFFFFFF;
            pay[119-30*i -: 30] = raw ^ w[119-30*i -: 30];
            par[i] = ^pay[119-30*i -: 30];
        end
        return {4'h5, par, pay};
    endfunction

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // One cycle: drive, compare at mid-cycle, advance the model at the edge.
    task automatic step(input logic v, input logic [29:0] d, input logic r,
                        input logic s, input string tag);
        logic [127:0] ef;
        logic hs, fl, rdy, pu;
        pkt_valid = v; pkt_data = d; frm_ready = r; sync_req = s;
        #1;
        hs  = mvalid & r;
        fl  = hs & ~s;
        rdy = (mcnt < 4) | fl;
        pu  = v & rdy;
        chk({"R10 frm_valid ", tag}, {127'd0, frm_valid}, {127'd0, mvalid});
        chk({"R7 pkt_ready ", tag}, {127'd0, pkt_ready}, {127'd0, rdy});
        if (s) begin
            chk({"R6 sync ", tag}, frm_data, sync_pattern);
        end else begin
            ef = exp_frame();
            if (frm_data[127:124] !== ef[127:124]) chk({"R1 header ", tag}, frm_data, ef);
            else if (frm_data[123:120] !== ef[123:120]) chk({"R2 parity ", tag}, frm_data, ef);
            else chk({"R4 payload ", tag}, frm_data, ef);
        end
        if (hs) mstate = scr_next(mstate);
        if (fl) begin
            mcnt = pu ? 1 : 0;
            if (pu) mslot[0] = d;
        end else if (pu) begin
            mslot[mcnt] = d;
            mcnt++;
        end
        @(posedge clk);
        mvalid = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; pkt_valid = 0; pkt_data = '0; frm_ready = 0;
        sync_req = 0; sync_pattern = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R10 valid low in reset", {127'd0, frm_valid}, 128'd0);
        mstate = 58'h2AB_CDEF_0123_4567; mcnt = 0; mvalid = 1'b0;
        for (int i = 0; i < 4; i++) mslot[i] = '0;
        rst_n = 1'b1;
        step(0, '0, 0, 0, "R10 release");
        step(0, '0, 1, 0, "R9 first idle frame");
        // Fill to full, then offer a fifth while stalled.
        for (int i = 0; i < 4; i++) step(1, 30'(32'h0100_0000 + i), 0, 0, "R3 fill order");
        step(1, 30'h2AAAAAAA, 0, 0, "R7 full stall");
        step(1, 30'h15555555, 1, 0, "R8 push at handshake");
        step(0, '0, 0, 0, "R8 next slot0");
        step(0, '0, 1, 0, "R5 one packet three idle");
        // Sweep partial occupancy 0..4.
        for (int n = 0; n <= 4; n++) begin
            for (int i = 0; i < n; i++) step(1, 30'(rnd()), 0, 0, "R5 partial fill");
            step(0, '0, 1, 0, "R5 partial frame");
        end
        // Sync with packets pending.
        step(1, 30'h0ABCDEF0, 0, 0, "R6 pend");
        step(1, 30'h1234567, 0, 0, "R6 pend");
        sync_pattern = {rnd(), rnd(), rnd(), rnd()};
        step(0, '0, 1, 1, "R6 sync frame");
        step(0, '0, 1, 1, "R6 sync frame");
        step(1, 30'h3000_0001, 0, 1, "R6 push during sync");
        step(0, '0, 1, 0, "R6 packets kept");
        // Pseudo-random sweep of all input combinations.
        for (int c = 0; c < 3000; c++) begin
            logic [31:0] r;
            r = rnd();
            if (r[7:4] == 4'd0) sync_pattern = {rnd(), rnd(), rnd(), rnd()};
            step(r[0], 30'(rnd()), r[1] & r[2], r[3] & (r[9:8] == 2'd0), "R3 sweep");
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule